// File: doc/BRIEF.md
# Overlapped Sample/Convert ADC Sequencer

This block steps through an ordered list of conversion slots each time a start trigger arrives. It models one sampler stage and one converter stage that run as a two-stage pipeline. Each slot has its own acquisition setting, and that setting fixes how long the sampler stays open for the slot. A conversion begins once its sampling window has closed and the converter is free. The sampler opens the window for the next slot a fixed number of clocks before the running conversion finishes. The converter therefore idles only when the next window is longer than that overlap.

A group is set by a slot count and a packed vector of acquisition settings. Both are captured when the trigger is accepted. Every finished conversion gives a one-clock end-of-conversion pulse. The pulse carries the slot index and a placeholder result word. After the last slot, a result-latch strobe and then a group-done pulse close the group. A trigger that arrives while the group is still running raises a sticky overflow flag and leaves the running group unchanged.

The clock is the converter clock. A slot of setting N costs 6 + max(N+1, 7) clocks after the first one.

Top module: `adc_seq`

## Requirements
- R1: A slot whose acquisition setting is N holds `sample_o` high for exactly N+1 consecutive clocks. Slot i's setting is `acq_i[i*6 +: 6]`.
- R2: Each conversion holds `convert_o` high for exactly 13 clocks. It starts no earlier than the clock after its slot's sampling window ends.
- R3: When a further slot remains, its sampling window opens in the 7th-from-last clock of the running conversion, so 6 clocks after that conversion started.
- R4: A conversion starts at the later of two clocks: the clock after its sampling window ends, or the clock after the previous conversion ends. A window longer than 7 clocks leaves the converter idle. A window shorter than 7 clocks is held until the converter is free.
- R5: After the trigger is accepted on a clock edge, slot 0 starts sampling 2 clocks later. Slots run in index order, and `slot_o` shows the index of the slot being sampled.
- R6: `eoc_o` pulses for one clock in the clock right after each conversion's last clock. During that pulse, `eoc_slot_o` gives the slot index and `res_o` gives the placeholder value 0x800 plus the slot index.
- R7: `latch_o` pulses one clock after the last slot's `eoc_o`, which is 2 clocks after the final conversion clock. `done_o` pulses in the clock after `latch_o`, and then the block is idle.
- R8: A trigger seen while a group is running sets `ovf_o` from the next clock on, and the running group's timing is unchanged. The next accepted trigger clears `ovf_o`.
- R9: The slot count is captured at the trigger. A count of 0 runs 1 slot, and a count above 8 runs 8 slots. Changes to `count_i` or `acq_i` after the trigger have no effect on the running group.
- R10: After reset, every output is low and the slot index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start trigger, sampled on each rising edge |
| count_i | input | 4 | Number of slots in the group |
| acq_i | input | 48 | Acquisition settings, 6 bits per slot, slot i at bits i*6 +: 6 |
| sample_o | output | 1 | Sampler window open |
| convert_o | output | 1 | Converter busy |
| slot_o | output | 3 | Index of the slot being sampled |
| eoc_o | output | 1 | End-of-conversion pulse |
| eoc_slot_o | output | 3 | Slot index that goes with `eoc_o` |
| res_o | output | 12 | Placeholder result that goes with `eoc_o` |
| latch_o | output | 1 | Final result-latch strobe |
| done_o | output | 1 | Group finished pulse |
| ovf_o | output | 1 | Sticky flag: a trigger arrived while busy |

## Verification
Cycle 0 is the clock after the edge that accepted the trigger. From the captured settings, the bench builds the schedule of sample-window starts, conversion starts, end-of-conversion pulses, the latch and done. Slot 0 samples from cycle 2. Each conversion starts the cycle after the later of its own window end and the previous conversion's end. The `eoc_o` pulse comes 13 cycles after a conversion starts, `latch_o` 1 cycle after that, and `done_o` 1 cycle after the latch. `ovf_o` is due one cycle after the stray trigger. Every output is compared on the falling edge of every cycle of the group against this schedule, so an early or late transition is caught in the exact cycle where it appears.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned DEF_MAX_SLOTS = 8;
  localparam int unsigned DEF_ACQ_W     = 6;
  localparam int unsigned DEF_CONV_CYC  = 13;
  localparam int unsigned DEF_OVL_CYC   = 7;
  localparam int unsigned DEF_START_LAT = 2;
  localparam int unsigned DEF_RES_W     = 12;
  localparam int unsigned DEF_PH_BASE   = 12'h800;
endpackage

// File: rtl/adc_seq_sampler.sv
module adc_seq_sampler #(
  parameter int unsigned ACQ_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ACQ_W-1:0] len_i,
  output logic             act_o,
  output logic             fin_o
);
  logic [ACQ_W-1:0] cnt_q;
  logic             act_q;

  // setting N -> N+1 clocks of sampling
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= len_i;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign act_o = act_q;
  assign fin_o = act_q && (cnt_q == '0);
endmodule

// File: rtl/adc_seq_conv.sv
module adc_seq_conv #(
  parameter int unsigned CONV_CYC = 13,
  parameter int unsigned OVL_CYC  = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic act_o,
  output logic last_o,
  output logic tap_o
);
  localparam int unsigned CW = $clog2(CONV_CYC);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= CW'(CONV_CYC - 1);
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign act_o  = act_q;
  assign last_o = act_q && (cnt_q == '0);
  // next sample opens the clock after this, OVL_CYC clocks before the end
  assign tap_o  = act_q && (cnt_q == CW'(OVL_CYC));
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned MAX_SLOTS = DEF_MAX_SLOTS,
  parameter int unsigned ACQ_W     = DEF_ACQ_W,
  parameter int unsigned CONV_CYC  = DEF_CONV_CYC,
  parameter int unsigned OVL_CYC   = DEF_OVL_CYC,
  parameter int unsigned START_LAT = DEF_START_LAT,
  parameter int unsigned RES_W     = DEF_RES_W,
  parameter int unsigned PH_BASE   = DEF_PH_BASE,
  localparam int unsigned SLOT_W   = $clog2(MAX_SLOTS),
  localparam int unsigned CNT_W    = $clog2(MAX_SLOTS + 1),
  localparam int unsigned LAT_W    = $clog2(START_LAT + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       trig_i,
  input  logic [CNT_W-1:0]           count_i,
  input  logic [MAX_SLOTS*ACQ_W-1:0] acq_i,
  output logic                       sample_o,
  output logic                       convert_o,
  output logic [SLOT_W-1:0]          slot_o,
  output logic                       eoc_o,
  output logic [SLOT_W-1:0]          eoc_slot_o,
  output logic [RES_W-1:0]           res_o,
  output logic                       latch_o,
  output logic                       done_o,
  output logic                       ovf_o
);
  logic                       busy_q, hold_q, ovf_q;
  logic [LAT_W-1:0]           lat_q;
  logic [CNT_W-1:0]           n_q;
  logic [MAX_SLOTS*ACQ_W-1:0] acq_q;
  logic [SLOT_W-1:0]          samp_slot_q, conv_slot_q, eoc_slot_q;
  logic [RES_W-1:0]           res_q;
  logic                       eoc_q, eoc_last_q, latch_q, done_q;

  logic accept, lat_fire, more, samp_start, conv_start;
  logic samp_act, samp_fin, conv_act, conv_last, conv_tap;
  logic [SLOT_W-1:0] nxt_slot;
  logic [CNT_W-1:0]  n_eff;

  always_comb begin
    if (count_i == '0)                        n_eff = CNT_W'(1);
    else if (count_i > CNT_W'(MAX_SLOTS))     n_eff = CNT_W'(MAX_SLOTS);
    else                                      n_eff = count_i;
  end

  assign accept     = trig_i && !busy_q;
  assign lat_fire   = busy_q && (lat_q == LAT_W'(1));
  assign more       = (CNT_W'(samp_slot_q) + CNT_W'(1)) < n_q;
  assign samp_start = lat_fire || (conv_tap && more);
  assign nxt_slot   = lat_fire ? '0 : samp_slot_q + 1'b1;
  assign conv_start = (samp_fin || hold_q) && (!conv_act || conv_last);

  adc_seq_sampler #(.ACQ_W(ACQ_W)) u_samp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (samp_start),
    .len_i   (acq_q[nxt_slot*ACQ_W +: ACQ_W]),
    .act_o   (samp_act),
    .fin_o   (samp_fin)
  );

  adc_seq_conv #(.CONV_CYC(CONV_CYC), .OVL_CYC(OVL_CYC)) u_conv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (conv_start),
    .act_o   (conv_act),
    .last_o  (conv_last),
    .tap_o   (conv_tap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      ovf_q       <= 1'b0;
      lat_q       <= '0;
      n_q         <= '0;
      acq_q       <= '0;
      samp_slot_q <= '0;
      hold_q      <= 1'b0;
      conv_slot_q <= '0;
    end else begin
      if (accept) begin
        busy_q      <= 1'b1;
        ovf_q       <= 1'b0;
        lat_q       <= LAT_W'(START_LAT);
        n_q         <= n_eff;
        acq_q       <= acq_i;
        samp_slot_q <= '0;
      end else begin
        if (trig_i) ovf_q <= 1'b1;
        if (latch_q) busy_q <= 1'b0;
        if (lat_q != '0) lat_q <= lat_q - 1'b1;
        if (samp_start) samp_slot_q <= nxt_slot;
      end
      // finished window waits here until the converter frees up
      if (conv_start) begin
        hold_q      <= 1'b0;
        conv_slot_q <= samp_slot_q;
      end else if (samp_fin) begin
        hold_q      <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_q      <= 1'b0;
      eoc_last_q <= 1'b0;
      eoc_slot_q <= '0;
      res_q      <= '0;
      latch_q    <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      eoc_q      <= conv_last;
      eoc_last_q <= conv_last && ((CNT_W'(conv_slot_q) + CNT_W'(1)) == n_q);
      if (conv_last) begin
        eoc_slot_q <= conv_slot_q;
        res_q      <= RES_W'(PH_BASE) + RES_W'(conv_slot_q);
      end
      latch_q    <= eoc_q && eoc_last_q;
      done_q     <= latch_q;
    end
  end

  assign sample_o   = samp_act;
  assign convert_o  = conv_act;
  assign slot_o     = samp_slot_q;
  assign eoc_o      = eoc_q;
  assign eoc_slot_o = eoc_slot_q;
  assign res_o      = res_q;
  assign latch_o    = latch_q;
  assign done_o     = done_q;
  assign ovf_o      = ovf_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic trig_i,
  input logic busy_i,
  input logic sample_i,
  input logic convert_i,
  input logic eoc_i,
  input logic latch_i,
  input logic done_i,
  input logic ovf_i
);
  AST_EOC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |=> !eoc_i); // R6
  AST_EOC_AFTER_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |-> $past(convert_i)); // R2
  AST_LATCH_AFTER_EOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |-> $past(eoc_i)); // R7
  AST_DONE_AFTER_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> done_i); // R7
  AST_IDLE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!sample_i && !convert_i)); // R7
  AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && busy_i) |=> ovf_i); // R8
  AST_START_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !busy_i) |=> !sample_i); // R5
endmodule

bind adc_seq adc_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .trig_i    (trig_i),
  .busy_i    (busy_q),
  .sample_i  (sample_o),
  .convert_i (convert_o),
  .eoc_i     (eoc_o),
  .latch_i   (latch_o),
  .done_i    (done_o),
  .ovf_i     (ovf_o)
);

// File: tb/sim_adc_seq.sv
`timescale 1ns/1ps
module sim_adc_seq;
  localparam int MAXS = 8;
  localparam int AW   = 6;
  localparam int CONV = 13;
  localparam int OVL  = 7;

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
  logic [3:0] count = '0;
  logic [MAXS*AW-1:0] acq = '0;
  logic sample, convert, eoc, latch, done, ovf;
  logic [2:0] slot, eoc_slot;
  logic [11:0] res;

  int checks = 0, errors = 0;
  bit finished = 0;
  int s_st[MAXS], s_len[MAXS], c_st[MAXS];

  always #2 clk = ~clk;

  adc_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .count_i(count), .acq_i(acq),
    .sample_o(sample), .convert_o(convert), .slot_o(slot), .eoc_o(eoc),
    .eoc_slot_o(eoc_slot), .res_o(res), .latch_o(latch), .done_o(done), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_n(input int c);
    if (c == 0) return 1;
    if (c > MAXS) return MAXS;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // one group; ovf_at < 0 means no stray trigger
  task automatic run_group(input int cnt, input logic [MAXS*AW-1:0] a,
                           input int ovf_at, input bit scramble);
    int n, last_done, eoc_seen;
    n = eff_n(cnt);
    for (int i = 0; i < n; i++) begin
      s_len[i] = int'(a[i*AW +: AW]) + 1;
      if (i == 0) s_st[i] = 2;
      else        s_st[i] = c_st[i-1] + (CONV - OVL);
      c_st[i] = (i == 0) ? s_st[i] + s_len[i]
                         : max2(s_st[i] + s_len[i], c_st[i-1] + CONV);
    end
    last_done = c_st[n-1] + CONV + 2;
    eoc_seen = 0;
    @(negedge clk);
    trig = 1'b1; count = 4'(cnt); acq = a;
    @(negedge clk);
    trig = 1'b0;
    for (int k = 0; k <= last_done + 1; k++) begin
      bit es, ec, ee; int eslot, sslot;
      es = 0; ec = 0; ee = 0; eslot = 0; sslot = 0;
      for (int i = 0; i < n; i++) begin
        if (k >= s_st[i] && k < s_st[i] + s_len[i]) begin es = 1; sslot = i; end
        if (k >= c_st[i] && k < c_st[i] + CONV) ec = 1;
        if (k == c_st[i] + CONV) begin ee = 1; eslot = i; end
      end
      chk(sample == es, "R1 R3 R5 sample", int'(sample), int'(es));
      if (es) chk(int'(slot) == sslot, "R5 slot", int'(slot), sslot);
      chk(convert == ec, "R2 R4 convert", int'(convert), int'(ec));
      chk(eoc == ee, "R6 eoc", int'(eoc), int'(ee));
      if (ee && eoc) begin
        eoc_seen++;
        chk(int'(eoc_slot) == eslot, "R6 eoc_slot", int'(eoc_slot), eslot);
        chk(int'(res) == 'h800 + eslot, "R6 res", int'(res), 'h800 + eslot);
      end
      chk(latch == (k == last_done - 1), "R7 latch", int'(latch), int'(k == last_done - 1));
      chk(done == (k == last_done), "R7 done", int'(done), int'(k == last_done));
      chk(ovf == (ovf_at >= 0 && k > ovf_at), "R8 ovf", int'(ovf), int'(ovf_at >= 0 && k > ovf_at));
      if (k == ovf_at) trig = 1'b1;
      else trig = 1'b0;
      if (scramble && k == 1) begin
        count = 4'($urandom_range(0, 15));
        acq = {$urandom(), $urandom()};
      end
      @(negedge clk);
    end
    chk(eoc_seen == n, "R9 slot count", eoc_seen, n);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({sample, convert, eoc, latch, done, ovf} == 6'b0, "R10 outputs", 0, 0);
    chk(slot == 3'd0, "R10 slot", int'(slot), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed: 7-clock slot then five 15-clock slots
    run_group(6, {12'd0, 6'd14, 6'd14, 6'd14, 6'd14, 6'd14, 6'd6}, -1, 0);
    // single slot, 7 clocks
    run_group(1, 48'd6, -1, 0);
    // 10-clock window: converter idles 3 clocks (R4)
    run_group(3, {30'd0, 6'd9, 6'd9, 6'd9}, -1, 0);
    // 1-clock windows held until converter free (R4)
    run_group(4, {24'd0, 6'd0, 6'd0, 6'd0, 6'd0}, -1, 0);
    // count 0 and clamp above max (R9)
    run_group(0, {8{6'd3}}, -1, 0);
    run_group(15, {8{6'd20}}, -1, 1);
    // stray trigger (R8), then cleared by the next group
    run_group(2, {36'd0, 6'd63, 6'd2}, 10, 0);
    run_group(2, {36'd0, 6'd5, 6'd1}, -1, 0);
    // constrained random
    for (int g = 0; g < 40; g++) begin
      logic [MAXS*AW-1:0] a;
      int cnt, ov;
      for (int i = 0; i < MAXS; i++)
        a[i*AW +: AW] = ($urandom_range(0, 3) == 0) ? 6'($urandom_range(0, 63))
                                                    : 6'($urandom_range(0, 16));
      cnt = $urandom_range(0, 10);
      ov = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : -1;
      run_group(cnt, a, ov, bit'($urandom_range(0, 1)));
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule